// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags and Relation Decode

This block is a purely combinational two's-complement arithmetic unit. It accepts two operands of a parameterised width (32 bits by default) and either adds them or subtracts the second from the first. Subtraction shares the single adder: the second operand is bit-inverted and the missing one is supplied through the adder's carry input, which is tied to the subtract control.

Next to the result it produces four condition flags: zero, negative, carry and signed overflow. After a subtraction, a decoder turns these flags into ten relation outputs that cover equality and the signed and unsigned orderings. This lets the unit double as a comparator. A saturate input can clamp an overflowing result to the largest positive or largest negative value. When saturation is off, the result wraps modulo 2^W. The flags always describe the raw, wrapped sum.

Top module: `addsub_cc`

## Requirements
- R1: With sub_i=0, and either sat_i=0 or no overflow, res_o equals (a_i + b_i) mod 2^W.
- R2: With sub_i=1, and either sat_i=0 or no overflow, res_o equals (a_i - b_i) mod 2^W.
- R3: z_o is 1 exactly when the wrapped sum is all zeros. After a subtraction, this means a_i equals b_i.
- R4: n_o equals the most significant bit of the wrapped sum.
- R5: c_o is the carry out of the top adder bit. For addition it is 1 when the unsigned sum reaches 2^W. For subtraction it is 1 when a_i >= b_i unsigned, so there is no borrow.
- R6: v_o is 1 exactly when the true signed result of the selected operation lies outside [-2^(W-1), 2^(W-1)-1].
- R7: After a subtraction, the signed relations hold for a_i against b_i as signed values. These relations are lt_o, le_o, gt_o, ge_o, eq_o and ne_o.
- R8: After a subtraction, the unsigned relations hold for a_i against b_i as unsigned values. These relations are ltu_o, leu_o, gtu_o and geu_o.
- R9: With sat_i=1 and v_o=1, res_o is 2^(W-1)-1 (0111...1) when the true result is positive, and -2^(W-1) (1000...0) when it is negative. The flags keep their unsaturated values.
- R10: When v_o=0, sat_i has no effect on res_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects a_i + b_i |
| sat_i | input | 1 | 1 clamps an overflowing result |
| res_o | output | W | Result |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| c_o | output | 1 | Carry / not-borrow flag |
| v_o | output | 1 | Signed overflow flag |
| lt_o | output | 1 | Signed less than |
| le_o | output | 1 | Signed less or equal |
| gt_o | output | 1 | Signed greater than |
| ge_o | output | 1 | Signed greater or equal |
| eq_o | output | 1 | Equal |
| ne_o | output | 1 | Not equal |
| ltu_o | output | 1 | Unsigned less than |
| leu_o | output | 1 | Unsigned less or equal |
| gtu_o | output | 1 | Unsigned greater than |
| geu_o | output | 1 | Unsigned greater or equal |

## Verification
The operands are drawn from zero, minus one, the most negative value and the most positive value, paired in every combination under both add and subtract.

- These pairs separate a carry out of the top bit from a signed overflow.
- They also separate a borrow from a signed ordering, such as the most negative value compared with one.
- Equal operands exercise the zero flag and the equality relations.
- Overflowing pairs, run with saturation on and off, distinguish the positive clamp, the negative clamp and wrapping.
- Non-overflowing pairs with saturation on show that the clamp stays idle.
- Random operands then cover carry chains that end in the middle of the word.

// File: rtl/addsub_cc.sv
module addsub_cc #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         sat_i,
  output logic [W-1:0] res_o,
  output logic         z_o,
  output logic         n_o,
  output logic         c_o,
  output logic         v_o,
  output logic         lt_o,
  output logic         le_o,
  output logic         gt_o,
  output logic         ge_o,
  output logic         eq_o,
  output logic         ne_o,
  output logic         ltu_o,
  output logic         leu_o,
  output logic         gtu_o,
  output logic         geu_o
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         cout;
  logic         slt;

  assign b_eff       = b_i ^ {W{sub_i}};
  assign {cout, sum} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};

  assign z_o = ~|sum;
  assign n_o = sum[W-1];
  assign c_o = cout;
  assign v_o = a_i[W-1] ^ b_eff[W-1] ^ sum[W-1] ^ cout;

  assign slt   = n_o ^ v_o;
  assign lt_o  = slt;
  assign le_o  = z_o | slt;
  assign ge_o  = ~slt;
  assign gt_o  = ~(z_o | slt);
  assign eq_o  = z_o;
  assign ne_o  = ~z_o;
  assign ltu_o = ~c_o;
  assign leu_o = ~c_o | z_o;
  assign geu_o = c_o;
  assign gtu_o = c_o & ~z_o;

  assign res_o = (sat_i && v_o) ? (sum[W-1] ? POS_LIM : NEG_LIM) : sum;

  always_comb begin
    if (sub_i) begin
      p_borrow_r5: assert (c_o == (a_i >= b_i));
      p_equal_r3:  assert (z_o == (a_i == b_i));
      p_slt_r7:    assert (lt_o == ($signed(a_i) < $signed(b_i)));
      p_ugt_r8:    assert (gtu_o == (a_i > b_i));
    end
    if (sat_i && v_o) begin
      p_clamp_r9: assert (res_o == POS_LIM || res_o == NEG_LIM);
    end
    if (!v_o) begin
      p_no_clamp_r10: assert (res_o == (sub_i ? a_i - b_i : a_i + b_i));
    end
  end
endmodule

// File: tb/tb_addsub_cc.sv
`timescale 1ns/1ps
module tb_addsub_cc;
  localparam int W = 32;
  localparam logic [W-1:0] PMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NMIN = {1'b1, {(W-1){1'b0}}};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic sub, sat;
  logic z, n, c, v, lt, le, gt, ge, eq, ne, ltu, leu, gtu, geu;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  addsub_cc #(.W(W)) dut (
    .a_i(a), .b_i(b), .sub_i(sub), .sat_i(sat), .res_o(res),
    .z_o(z), .n_o(n), .c_o(c), .v_o(v),
    .lt_o(lt), .le_o(le), .gt_o(gt), .ge_o(ge), .eq_o(eq), .ne_o(ne),
    .ltu_o(ltu), .leu_o(leu), .gtu_o(gtu), .geu_o(geu)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h sub=%0b sat=%0b actual=%h expected=%h", req, a, b, sub, sat, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic isub, input logic isat);
    longint sa, sb, tr;
    logic [W:0] ua, ub;
    logic [W-1:0] wrap, expres;
    logic ovf, carry;
    @(negedge clk);
    a = ia; b = ib; sub = isub; sat = isat;
    #2;
    sa = longint'($signed(ia)); sb = longint'($signed(ib));
    ua = {1'b0, ia}; ub = {1'b0, ib};
    tr = isub ? sa - sb : sa + sb;
    wrap  = isub ? ia - ib : ia + ib;
    ovf   = (tr > longint'($signed(PMAX))) || (tr < longint'($signed(NMIN)));
    carry = isub ? (ia >= ib) : ((ua + ub) >= (1 << W));
    expres = (isat && ovf) ? ((tr > 0) ? PMAX : NMIN) : wrap;
    if (isat && ovf) chk("R9 clamp", res, expres);
    else if (isub)   chk("R2 difference", res, expres);
    else             chk("R1 sum", res, expres);
    chk("R3 zero", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, wrap == '0});
    chk("R4 negative", {{(W-1){1'b0}}, n}, {{(W-1){1'b0}}, wrap[W-1]});
    chk("R5 carry", {{(W-1){1'b0}}, c}, {{(W-1){1'b0}}, carry});
    chk("R6 overflow", {{(W-1){1'b0}}, v}, {{(W-1){1'b0}}, ovf});
    if (isub) begin
      chk("R7 signed rel", {{(W-6){1'b0}}, lt, le, gt, ge, eq, ne},
          {{(W-6){1'b0}}, sa < sb, sa <= sb, sa > sb, sa >= sb, sa == sb, sa != sb});
      chk("R8 unsigned rel", {{(W-4){1'b0}}, ltu, leu, gtu, geu},
          {{(W-4){1'b0}}, ia < ib, ia <= ib, ia > ib, ia >= ib});
    end
  endtask

  task automatic t_idle;
    run('0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_corners;
    logic [W-1:0] vals [4];
    vals[0] = '0; vals[1] = '1; vals[2] = NMIN; vals[3] = PMAX;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int s = 0; s < 2; s++)
          for (int t = 0; t < 2; t++)
            run(vals[i], vals[j], s[0], t[0]);
  endtask

  task automatic t_saturate;
    run(PMAX, 32'd1, 1'b0, 1'b1);
    run(NMIN, 32'd1, 1'b1, 1'b1);
    run(PMAX, 32'd1, 1'b0, 1'b0);
    run(32'd5, 32'd7, 1'b1, 1'b1);
    run(NMIN, NMIN, 1'b0, 1'b1);
  endtask

  task automatic t_compare;
    run(32'd42, 32'd42, 1'b1, 1'b0);
    run(NMIN, 32'd1, 1'b1, 1'b0);
    run(32'd1, '1, 1'b1, 1'b0);
    run(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
  endtask

  task automatic t_random;
    for (int k = 0; k < 200; k++)
      run($urandom, $urandom, 1'($urandom), 1'($urandom));
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0; sat = 1'b0;
    t_idle;
    t_corners;
    t_saturate;
    t_compare;
    t_random;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule